// File: doc/BRIEF.md
# Sync-Triggered Integration Window Controller

This block is the digital timing and counting core of a two-channel integrating converter. The analog front end emits one count tick per converted charge packet. The block counts these ticks over an integration window, then latches the total together with the window length and the channel it belongs to, and pulses a one-cycle valid strobe.

The window comes from one of two sources. With internal timing, the block opens a window by itself and closes it after exactly 2^n clock cycles, where n is the selected resolution. Windows then follow back to back. With external timing, a host writes a sync bit, which reaches the block as a one-cycle sync pulse. The first sync opens a window. Every later sync closes the open window and opens the next one on the same clock edge. The window length is then the number of bus-clock ticks seen between the two syncs.

In the alternating mode the channel toggles at each window close. Three syncs therefore give one result for each channel. The event counter saturates rather than wrapping, and a sticky flag records that counts were lost.

Top module: `integ_window_ctl`

## Requirements
- R1: After reset, `resultValid`, `overflow`, `chanTag`, `result` and `windowLen` are all 0.
- R2: `cmdByte[5]` selects external timing (1) or internal timing (0). `cmdByte[3:2]` selects the channel mode: 00 = channel 0 only, 01 = channel 1 only, 1x = alternating. `cmdByte[1:0]` selects the resolution n = 4 × (field + 1), giving 4, 8, 12 or 16.
- R3: With internal timing, a window opens on the first clock edge in idle. Each window lasts exactly 2^n clock edges, and the next window follows with no gap. At each close, `result` equals the number of edges inside the window that had `cntTick` high, and `windowLen` equals 2^n.
- R4: With external timing, a sync received in idle only opens a window. It produces no result and no valid strobe.
- R5: With external timing, each sync received while a window is open closes that window and opens the next one on the same edge. Ticks sampled on that edge belong to the closing window. `windowLen` equals the number of edges with `busTick` high inside the window.
- R6: In alternating mode the first window after idle is channel 0, and the channel toggles at every close. In the single-channel modes the tag stays at the selected channel.
- R7: `result`, `windowLen` and `chanTag` are updated together on the edge that closes a window. `resultValid` is high for exactly the cycle after that edge, and the three values hold until the next close.
- R8: The event count saturates at 65535. A tick that arrives while the count is already at 65535 sets `overflow`.
- R9: `overflow` stays set until a cycle with `resultRead` high clears it. A new lost count in that same cycle takes priority over the clear.
- R10: Any change in `cmdByte` bits 5, 3:2 or 1:0 aborts the open window with no result and returns the block to idle. A sync on that same edge is ignored.
- R11: With external timing, `windowLen` saturates at 131071 (2^17 − 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdByte | input | 8 | Command register contents: timing select, channel mode, resolution |
| syncPulse | input | 1 | One-cycle pulse for each sync bit written by the host |
| cntTick | input | 1 | One converter event per high cycle |
| busTick | input | 1 | One bus-clock period per high cycle |
| resultRead | input | 1 | Host has read the result; clears `overflow` |
| result | output | 16 | Latched event count of the last closed window |
| windowLen | output | 17 | Latched length of the last window (clock cycles internally, bus ticks externally) |
| chanTag | output | 1 | Channel of the last closed window |
| resultValid | output | 1 | One-cycle strobe after each window close |
| overflow | output | 1 | Sticky lost-count flag |

## Verification
The window position and the channel toggle live in internal registers. A wrong value in either shows up at the ports only at the next close. At that point `resultValid` fires on the wrong cycle, `windowLen` or `result` is off, or `chanTag` repeats. The delay is at most one window, which is 2^n cycles with internal timing or one sync interval with external timing.

A count that wraps instead of saturating only becomes visible as a small `result` after a very long window. A leaked abort becomes visible as a valid strobe on the sync that should merely open a window. The bench therefore compares every output against a behavioural model on every clock. It also forces one window past both saturation limits.

// File: rtl/intwin_pkg.sv
package intwin_pkg;

  typedef struct packed {
    logic       ext;
    logic [1:0] mode;
    logic [1:0] res;
  } winCfg_t;

  typedef struct packed {
    logic openWin;
    logic closeWin;
    logic abortWin;
    logic counting;
  } winStrobe_t;

endpackage

// File: rtl/winseq_ctl.sv
module winseq_ctl
  import intwin_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RES_STEP = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] cmdByte,
  input  logic       syncPulse,
  output winStrobe_t strobe,
  output logic       curChan,
  output logic       extMode,
  output logic [4:0] resN
);

  winCfg_t          cfgNow, cfgQ;
  logic             activeQ, chanQ;
  logic [CNT_W-1:0] cycQ, cycLim;
  logic             cfgChg, startCond, closeCond;

  assign cfgNow    = '{ext: cmdByte[5], mode: cmdByte[3:2], res: cmdByte[1:0]};
  assign cfgChg    = (cfgNow != cfgQ);
  assign resN      = 5'(RES_STEP) * (5'(cfgQ.res) + 5'd1);
  assign cycLim    = ~({CNT_W{1'b1}} << resN);
  assign startCond = cfgQ.ext ? syncPulse : 1'b1;
  assign closeCond = cfgQ.ext ? syncPulse : (cycQ == cycLim);

  assign strobe.abortWin = cfgChg;
  assign strobe.openWin  = !cfgChg && !activeQ && startCond;
  assign strobe.closeWin = !cfgChg && activeQ && closeCond;
  assign strobe.counting = !cfgChg && activeQ;
  assign curChan = chanQ;
  assign extMode = cfgQ.ext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      activeQ <= 1'b0;
      chanQ   <= 1'b0;
      cycQ    <= '0;
    end else begin
      cfgQ <= cfgNow;
      if (strobe.abortWin) begin
        activeQ <= 1'b0;
        cycQ    <= '0;
      end else if (strobe.openWin) begin
        activeQ <= 1'b1;
        cycQ    <= '0;
        chanQ   <= (cfgQ.mode == 2'b01);
      end else if (strobe.closeWin) begin
        cycQ <= '0;
        if (cfgQ.mode[1]) chanQ <= ~chanQ;
      end else if (activeQ) begin
        cycQ <= cycQ + 1'b1;
      end
    end
  end

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.abortWin |=> !activeQ); // R10

  AST_DUAL_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.closeWin && cfgQ.mode[1]) |=> (chanQ != $past(chanQ))); // R6

  AST_INT_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && !cfgQ.ext && !cfgChg && cycQ != cycLim) |-> !strobe.closeWin); // R3

endmodule

// File: rtl/winacc_dp.sv
module winacc_dp
  import intwin_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  winStrobe_t       strobe,
  input  logic             curChan,
  input  logic             extMode,
  input  logic [4:0]       resN,
  input  logic             cntTick,
  input  logic             busTick,
  input  logic             resultRead,
  output logic [CNT_W-1:0] result,
  output logic [LEN_W-1:0] windowLen,
  output logic             chanTag,
  output logic             resultValid,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [CNT_W-1:0] cntQ, cntNext;
  logic [LEN_W-1:0] lenQ, lenNext, intLen;
  logic             lostTick;

  assign lostTick = strobe.counting && cntTick && (cntQ == CNT_MAX);
  assign cntNext  = (cntQ == CNT_MAX) ? cntQ : cntQ + CNT_W'(cntTick);
  assign lenNext  = (lenQ == LEN_MAX) ? lenQ : lenQ + LEN_W'(busTick);
  assign intLen   = LEN_W'(1) << resN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ        <= '0;
      lenQ        <= '0;
      result      <= '0;
      windowLen   <= '0;
      chanTag     <= 1'b0;
      resultValid <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (strobe.openWin) begin
        cntQ <= '0;
        lenQ <= '0;
      end else if (strobe.closeWin) begin
        result      <= cntNext;
        windowLen   <= extMode ? lenNext : intLen;
        chanTag     <= curChan;
        resultValid <= 1'b1;
        cntQ        <= '0;
        lenQ        <= '0;
      end else if (strobe.counting) begin
        cntQ <= cntNext;
        lenQ <= lenNext;
      end
      if (lostTick)        overflow <= 1'b1;
      else if (resultRead) overflow <= 1'b0;
    end
  end

  AST_OPEN_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.openWin |=> !resultValid); // R4

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.counting && !strobe.closeWin && cntQ == CNT_MAX) |=> (cntQ == CNT_MAX)); // R8

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !resultRead) |=> overflow); // R9

  AST_VALID_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.closeWin) |=> ($stable(result) && $stable(chanTag) && !resultValid)); // R7

endmodule

// File: rtl/integ_window_ctl.sv
module integ_window_ctl
  import intwin_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RES_STEP = 4,
  parameter int LEN_W    = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       cmdByte,
  input  logic             syncPulse,
  input  logic             cntTick,
  input  logic             busTick,
  input  logic             resultRead,
  output logic [CNT_W-1:0] result,
  output logic [LEN_W-1:0] windowLen,
  output logic             chanTag,
  output logic             resultValid,
  output logic             overflow
);

  winStrobe_t strobe;
  logic       curChan, extMode;
  logic [4:0] resN;

  winseq_ctl #(.CNT_W(CNT_W), .RES_STEP(RES_STEP)) i_ctl (
    .clk(clk), .rstN(rstN), .cmdByte(cmdByte), .syncPulse(syncPulse),
    .strobe(strobe), .curChan(curChan), .extMode(extMode), .resN(resN)
  );

  winacc_dp #(.CNT_W(CNT_W), .LEN_W(LEN_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curChan(curChan),
    .extMode(extMode), .resN(resN), .cntTick(cntTick), .busTick(busTick),
    .resultRead(resultRead), .result(result), .windowLen(windowLen),
    .chanTag(chanTag), .resultValid(resultValid), .overflow(overflow)
  );

endmodule

// File: tb/test_integ_window_ctl.sv
`timescale 1ns/1ps
module test_integ_window_ctl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cmdByte = 8'h00;
  logic        syncPulse = 1'b0, cntTick = 1'b0, busTick = 1'b0, resultRead = 1'b0;
  logic [15:0] result;
  logic [16:0] windowLen;
  logic        chanTag, resultValid, overflow;

  int compared = 0, mismatched = 0, cycles = 0;
  bit toggleEn = 0, done = 0;

  always #2.5 clk = ~clk;

  integ_window_ctl i_integ_window_ctl (
    .clk(clk), .rstN(rstN), .cmdByte(cmdByte), .syncPulse(syncPulse),
    .cntTick(cntTick), .busTick(busTick), .resultRead(resultRead),
    .result(result), .windowLen(windowLen), .chanTag(chanTag),
    .resultValid(resultValid), .overflow(overflow)
  );

  // behavioural reference model
  int mCfg, mActive, mCyc, mCnt, mLen, mChan, mRes, mWl, mTag, mValid, mOvf;
  always @(posedge clk) begin
    int cfg, n, mode, ext, closeIt;
    if (!rstN) begin
      mCfg = 0; mActive = 0; mCyc = 0; mCnt = 0; mLen = 0; mChan = 0;
      mRes = 0; mWl = 0; mTag = 0; mValid = 0; mOvf = 0;
    end else begin
      mValid = 0;
      cfg  = {cmdByte[5], cmdByte[3:2], cmdByte[1:0]};
      ext  = (mCfg >> 4) & 1;
      mode = (mCfg >> 2) & 3;
      n    = 4 * ((mCfg & 3) + 1);
      if (resultRead) mOvf = 0;
      if (cfg != mCfg) begin
        mCfg = cfg; mActive = 0; mCyc = 0;
      end else if (mActive == 0) begin
        if (ext == 0 || syncPulse) begin
          mActive = 1; mCyc = 0; mCnt = 0; mLen = 0; mChan = (mode == 1) ? 1 : 0;
        end
      end else begin
        if (cntTick) begin
          if (mCnt == 65535) mOvf = 1; else mCnt++;
        end
        if (busTick && mLen < 131071) mLen++;
        closeIt = ext ? syncPulse : (mCyc == (1 << n) - 1);
        if (closeIt) begin
          mRes = mCnt; mWl = ext ? mLen : (1 << n); mTag = mChan; mValid = 1;
          mCnt = 0; mLen = 0; mCyc = 0;
          if (mode >= 2) mChan = 1 - mChan;
        end else mCyc++;
      end
    end
  end

  always @(negedge clk) begin
    if (toggleEn) cntTick <= ~cntTick;
  end

  always @(negedge clk) begin
    cycles++;
    if (rstN && !done) begin
      compared++;
      if (result !== 16'(mRes) || windowLen !== 17'(mWl) || chanTag !== 1'(mTag)
          || resultValid !== 1'(mValid)) begin
        mismatched++;
        $display("FAIL R7 cycle %0d: res/len/tag/valid actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                 cycles, result, windowLen, chanTag, resultValid, mRes, mWl, mTag, mValid);
      end
      if (overflow !== 1'(mOvf)) begin
        mismatched++;
        $display("FAIL R9 cycle %0d: overflow actual %0d expected %0d", cycles, overflow, mOvf);
      end
    end
    if (cycles > 180000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic waitValid();
    for (int i = 0; i < 2000; i++) begin
      if (resultValid) return;
      step(1);
    end
  endtask

  task automatic pulseSync();
    syncPulse = 1'b1;
    step(1);
    syncPulse = 1'b0;
  endtask

  initial begin
    int gap;
    step(4);
    rstN = 1'b1;
    step(1);
    check("R1 valid", resultValid, 0);
    check("R1 overflow", overflow, 0);
    check("R1 result", result, 0);
    check("R1 windowLen", windowLen, 0);
    check("R1 chanTag", chanTag, 0);

    // R3: internal timing, n=4, tick on every other cycle
    toggleEn = 1;
    waitValid();
    step(1);
    waitValid();
    check("R3 result half rate", result, 8);
    check("R3 windowLen", windowLen, 16);
    check("R2 single channel 0 tag", chanTag, 0);
    gap = 0;
    step(1);
    while (!resultValid && gap < 100) begin step(1); gap++; end
    check("R3 window spacing", gap + 1, 16);
    toggleEn = 0;
    step(1);
    cntTick = 1'b0;

    // R6: internal alternating, n=8, tick every cycle
    cntTick = 1'b1;
    cmdByte = 8'h09;
    step(1);
    waitValid();
    check("R3 result full rate n=8", result, 256);
    check("R6 first tag", chanTag, 0);
    step(1);
    waitValid();
    check("R6 second tag", chanTag, 1);
    cntTick = 1'b0;

    // R4/R5: external, single channel 1
    cmdByte = 8'h24;
    step(3);
    pulseSync();
    check("R4 open gives no result", resultValid, 0);
    for (int i = 0; i < 7; i++) begin
      cntTick = (i < 3);
      busTick = 1'b1;
      step(1);
    end
    syncPulse = 1'b1; cntTick = 1'b1; busTick = 1'b1;
    step(1);
    syncPulse = 1'b0; cntTick = 1'b0; busTick = 1'b0;
    check("R5 valid on sync", resultValid, 1);
    check("R5 result with close-edge tick", result, 4);
    check("R5 windowLen bus ticks", windowLen, 8);
    check("R6 single channel 1 tag", chanTag, 1);
    step(1);
    check("R7 valid one cycle", resultValid, 0);
    check("R7 result held", result, 4);

    // R6: external alternating, three syncs
    cmdByte = 8'h28;
    step(2);
    pulseSync();
    check("R4 dual open silent", resultValid, 0);
    step(3);
    pulseSync();
    check("R6 ext first tag", chanTag, 0);
    step(3);
    pulseSync();
    check("R6 ext second tag", chanTag, 1);
    check("R6 ext second valid", resultValid, 1);
    step(2);
    pulseSync();
    check("R6 ext wrap tag", chanTag, 0);

    // R10: abort with simultaneous sync
    cmdByte = 8'h20;
    step(2);
    pulseSync();
    step(3);
    cmdByte = 8'h21; syncPulse = 1'b1;
    step(1);
    syncPulse = 1'b0;
    check("R10 abort no result", resultValid, 0);
    step(3);
    pulseSync();
    check("R10 idle after abort", resultValid, 0);
    step(2);
    pulseSync();
    check("R10 later close", resultValid, 1);

    // R8/R11/R9: saturation
    cmdByte = 8'h20;
    step(2);
    pulseSync();
    cntTick = 1'b1; busTick = 1'b1;
    step(131100);
    pulseSync();
    cntTick = 1'b0; busTick = 1'b0;
    check("R8 result saturated", result, 65535);
    check("R8 overflow set", overflow, 1);
    check("R11 windowLen saturated", windowLen, 131071);
    step(5);
    check("R9 overflow sticky", overflow, 1);
    resultRead = 1'b1;
    step(1);
    resultRead = 1'b0;
    check("R9 overflow cleared by read", overflow, 0);

    step(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule